// File: doc/BRIEF.md
# Row Single-to-Half Narrowing Packer

The block picks a 64-byte window out of one row of a tile, converts each of the sixteen 32-bit floating-point elements in that window to a 16-bit floating-point value, and returns the results as one 512-bit vector. Each result stays in its own 32-bit lane. A request carries a 32-bit selector. The low half of the selector names the row. The high half names which 64-byte chunk of the row to read.

Two mode bits travel with each request. One picks the target format: bfloat16 or IEEE binary16. The other places the 16-bit result in the upper or the lower half of its lane, and the other half of the lane is cleared. A lane is cleared entirely when its element lies at or beyond the configured row width in bytes. The tile storage sits outside the block. The block drives a row index, takes back the whole row on the same cycle, and registers its result one cycle after the request.

Top module: `row_half_packer`

## Requirements
- R1: `rd_row` equals `req_sel[15:0]`. Lane i reads the 32-bit element at dword index `req_sel[31:16]*16 + i` of the returned row, where dword k occupies `rd_data[32k+31:32k]`.
- R2: With `req_fmt`=0 (bfloat16), a finite or infinite input is rounded to nearest even at bit 16. A carry out of the mantissa moves into the exponent.
- R3: With `req_fmt`=0, a NaN input becomes `{sign, 8'hFF, 1, input[21:16]}`. This is a quiet NaN that keeps the sign, and infinities map to infinities.
- R4: With `req_fmt`=1 (binary16), an input in the binary16 normal range is rebiased from 127 to 15 and rounded to nearest even. A finite input that rounds above the largest finite binary16 value becomes a same-sign infinity (0x7C00 or 0xFC00).
- R5: With `req_fmt`=1, an input below the binary16 normal range becomes a correctly rounded (nearest even) subnormal or a signed zero. Rounding up can reach the smallest normal, 0x0400.
- R6: With `req_fmt`=1, an infinity becomes 0x7C00 or 0xFC00. A NaN becomes `{sign, 5'h1F, 1, input[21:13]}`.
- R7: With `req_hi`=1, the converted value sits in lane bits [31:16] and lane bits [15:0] are zero.
- R8: With `req_hi`=0, the converted value sits in lane bits [15:0] and lane bits [31:16] are zero.
- R9: A lane whose dword index is at least `cfg_colsb/4` (rounded down), or lies outside the row bus, outputs 32'h0 in either placement mode.
- R10: After reset `out_valid`=0 and `out_vec`=0. `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. `out_vec` changes only on a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 32 | Selector: row in [15:0], 64-byte chunk number in [31:16] |
| req_fmt | input | 1 | Target format: 0 bfloat16, 1 binary16 |
| req_hi | input | 1 | Placement: 1 upper half of lane, 0 lower half |
| cfg_colsb | input | 16 | Configured row width in bytes |
| rd_row | output | 16 | Row index presented to the tile storage |
| rd_data | input | 1024 | Row contents returned for `rd_row` in the same cycle |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_vec | output | 512 | Sixteen 32-bit result lanes |

## Verification
A single row holds 32 chosen binary32 values, and they are read under all four format and placement combinations. The values include ties that go down with an even result and up with an odd one, values just above a tie, binary16 overflow at 65520 and -65536, the subnormal-to-normal carry, the smallest subnormal, a half-unit tie that goes to zero, and signed and quiet NaNs. Together they separate the bfloat16 and binary16 rounding points and the subnormal and overflow paths. A second row stores the same values with every sign flipped, which shows that the row index is really used. Row widths of 40, 42 and 72 bytes and an out-of-row chunk show whether lanes are cut off at the floor of width/4. Idle cycles between requests show that the strobe pulses once and that the vector is held.

// File: rtl/row_half_pkg.sv
package row_half_pkg;
   typedef enum logic {
      NARROW_BF16 = 1'b0,
      NARROW_FP16 = 1'b1
   } narrow_fmt_e;

   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned HALF_BITS = 16;
   localparam int unsigned SEL_BITS  = 32;
endpackage

// File: rtl/narrow_bf16.sv
module narrow_bf16 (
   input  logic [31:0] a,
   output logic [15:0] y
);
   logic is_nan;
   logic rnd_up;

   always_comb begin
      is_nan = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
      rnd_up = a[15] & ((|a[14:0]) | a[16]);
      if (is_nan) y = {a[31], 8'hFF, 1'b1, a[21:16]};
      else        y = a[31:16] + {15'd0, rnd_up};
   end

   always_comb begin
      // R3
      if (is_nan) bf_nan_chk: assert (y[14:6] == 9'h1FF && y[15] == a[31]);
   end
endmodule

// File: rtl/narrow_fp16.sv
module narrow_fp16 (
   input  logic [31:0] a,
   output logic [15:0] y
);
   logic        sgn;
   logic [7:0]  ex;
   logic [22:0] mt;
   logic        is_nan, is_inf, too_big, is_norm;
   logic [14:0] nrm_base, nrm_val, sub_val;
   logic        nrm_up, sub_up;
   logic [4:0]  shamt;
   logic [23:0] sig;
   logic [39:0] ext;
   logic [14:0] mag;

   always_comb begin
      sgn     = a[31];
      ex      = a[30:23];
      mt      = a[22:0];
      is_nan  = (ex == 8'hFF) && (mt != 23'd0);
      is_inf  = (ex == 8'hFF) && (mt == 23'd0);
      too_big = (ex >= 8'd143);
      is_norm = (ex >= 8'd113);
      // normal path: rebias 127 -> 15
      nrm_base = {5'(ex - 8'd112), mt[22:13]};
      nrm_up   = mt[12] & ((|mt[11:0]) | mt[13]);
      nrm_val  = nrm_base + {14'd0, nrm_up};
      // subnormal path: units of 2^-24, shift = 126 - ex = 14 + shamt
      shamt   = (ex > 8'd96) ? 5'(8'd112 - ex) : 5'd16;
      sig     = {ex != 8'd0, mt};
      ext     = {sig, 16'd0} >> shamt;
      sub_up  = ext[29] & ((|ext[28:0]) | ext[30]);
      sub_val = {5'd0, ext[39:30]} + {14'd0, sub_up};
      if (is_nan)               mag = {5'h1F, 1'b1, mt[21:13]};
      else if (is_inf | too_big) mag = 15'h7C00;
      else if (is_norm)         mag = nrm_val;
      else                      mag = sub_val;
      y = {sgn, mag};
   end

   always_comb begin
      // R6
      if (is_inf) fp_inf_chk: assert (y[14:0] == 15'h7C00 && y[15] == a[31]);
   end
endmodule

// File: rtl/half_lane.sv
module half_lane
   import row_half_pkg::*;
(
   input  logic [WORD_BITS-1:0] elem,
   input  logic                 live,
   input  narrow_fmt_e          fmt,
   input  logic                 hi,
   output logic [WORD_BITS-1:0] lane
);
   logic [HALF_BITS-1:0] bf_val, fp_val, pick;

   narrow_bf16 u_bf (.a(elem), .y(bf_val));
   narrow_fp16 u_fp (.a(elem), .y(fp_val));

   always_comb begin
      pick = (fmt == NARROW_FP16) ? fp_val : bf_val;
      if (!live)   lane = '0;
      else if (hi) lane = {pick, {HALF_BITS{1'b0}}};
      else         lane = {{HALF_BITS{1'b0}}, pick};
   end
endmodule

// File: rtl/row_half_packer.sv
module row_half_packer
   import row_half_pkg::*;
#(
   parameter int unsigned LANES     = 16,
   parameter int unsigned ROW_BYTES = 128,
   parameter int unsigned COLS_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [SEL_BITS-1:0]      req_sel,
   input  logic                     req_fmt,
   input  logic                     req_hi,
   input  logic [COLS_W-1:0]        cfg_colsb,
   output logic [15:0]              rd_row,
   input  logic [ROW_BYTES*8-1:0]   rd_data,
   output logic                     out_valid,
   output logic [LANES*WORD_BITS-1:0] out_vec
);
   localparam int unsigned ROW_DW  = ROW_BYTES / 4;
   localparam int unsigned RDW_W   = (ROW_DW > 1) ? $clog2(ROW_DW) : 1;
   localparam int unsigned LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int unsigned DIDX_W  = 16 + LANE_W + 1;
   localparam int unsigned CMP_W   = ((DIDX_W + 3) > COLS_W) ? (DIDX_W + 3) : COLS_W;
   localparam int unsigned VEC_W   = LANES * WORD_BITS;

   if (ROW_BYTES % 4 != 0) begin : g_bad_row
      $error("ROW_BYTES must be a whole number of dwords");
   end
   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("LANES out of supported range");
   end
   if (COLS_W < 3) begin : g_bad_cols
      $error("COLS_W too narrow");
   end

   logic [15:0]         chunk;
   logic [WORD_BITS-1:0] row_dw [ROW_DW];
   logic [LANES-1:0]    lane_live;
   logic [VEC_W-1:0]    vec_d;
   narrow_fmt_e         fmt;

   assign rd_row = req_sel[15:0];
   assign chunk  = req_sel[31:16];
   assign fmt    = narrow_fmt_e'(req_fmt);

   for (genvar k = 0; k < ROW_DW; k++) begin : g_dw
      assign row_dw[k] = rd_data[WORD_BITS*k +: WORD_BITS];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [DIDX_W-1:0]    didx;
      logic [CMP_W-1:0]     end_byte;
      logic                 in_row;
      logic [WORD_BITS-1:0] elem;

      always_comb begin
         didx     = DIDX_W'(chunk) * DIDX_W'(LANES) + DIDX_W'(i);
         end_byte = CMP_W'({didx, 2'b00}) + CMP_W'(4);
         in_row   = (didx < DIDX_W'(ROW_DW));
         lane_live[i] = in_row && (end_byte <= CMP_W'(cfg_colsb));
         elem = in_row ? row_dw[didx[RDW_W-1:0]] : '0;
      end

      half_lane u_lane (
         .elem (elem),
         .live (lane_live[i]),
         .fmt  (fmt),
         .hi   (req_hi),
         .lane (vec_d[WORD_BITS*i +: WORD_BITS])
      );

      // R9
      dead_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !lane_live[i]) |=> (out_vec[WORD_BITS*i +: WORD_BITS] == '0));
      // R7
      hi_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_hi) |=> (out_vec[WORD_BITS*i +: HALF_BITS] == '0));
      // R8
      lo_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_hi) |=> (out_vec[WORD_BITS*i+HALF_BITS +: HALF_BITS] == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) out_vec <= vec_d;
      end
   end

   // R10
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   // R10
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   // R10
   hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(out_vec));
endmodule

// File: tb/sim_row_half_packer.sv
module sim_row_half_packer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_sel = '0;
   logic         req_fmt = 1'b0;
   logic         req_hi = 1'b0;
   logic [15:0]  cfg_colsb = 16'd128;
   logic [15:0]  rd_row;
   logic [1023:0] rd_data;
   logic         out_valid;
   logic [511:0] out_vec;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   logic [31:0] src [32];
   logic [15:0] bfx [32];
   logic [15:0] fpx [32];
   logic [1023:0] rows [2];

   always #5 clk = ~clk;

   row_half_packer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_fmt(req_fmt), .req_hi(req_hi), .cfg_colsb(cfg_colsb),
      .rd_row(rd_row), .rd_data(rd_data), .out_valid(out_valid), .out_vec(out_vec)
   );

   always_comb rd_data = (rd_row < 16'd2) ? rows[rd_row[0]] : '0;

   task automatic check(input bit ok, input string req, input logic [511:0] act,
                        input logic [511:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_lane(input int row, input int chunk, input int i,
                                            input bit fmt, input bit hi, input int colsb);
      int d;
      logic [15:0] v;
      d = chunk * 16 + i;
      if (d >= colsb / 4 || d >= 32 || row > 1) return 32'h0;
      v = fmt ? fpx[d] : bfx[d];
      if (row == 1) v = v ^ 16'h8000;
      return hi ? {v, 16'h0} : {16'h0, v};
   endfunction

   // Issues one request and checks the vector one cycle later.
   task automatic run(input int row, input int chunk, input bit fmt, input bit hi,
                      input int colsb, input string req);
      logic [511:0] exp;
      @(negedge clk);
      req_sel   = {16'(chunk), 16'(row)};
      req_fmt   = fmt;
      req_hi    = hi;
      cfg_colsb = 16'(colsb);
      req_valid = 1'b1;
      #1;
      check(rd_row == 16'(row), "R1 row index", 512'(rd_row), 512'(row));
      for (int i = 0; i < 16; i++) exp[32*i +: 32] = exp_lane(row, chunk, i, fmt, hi, colsb);
      @(negedge clk);
      req_valid = 1'b0;
      check(out_valid == 1'b1, "R10 strobe", 512'(out_valid), 512'd1);
      check(out_vec == exp, req, out_vec, exp);
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0, "R10 reset strobe", 512'(out_valid), 512'd0);
      check(out_vec == '0, "R10 reset vector", out_vec, '0);
   endtask

   task automatic t_bf16();
      run(0, 0, 1'b0, 1'b0, 128, "R2 R3 R8 bf16 low chunk0");
      run(0, 1, 1'b0, 1'b1, 128, "R2 R7 bf16 high chunk1");
      run(0, 0, 1'b0, 1'b1, 128, "R3 R7 bf16 high chunk0");
   endtask

   task automatic t_fp16();
      run(0, 0, 1'b1, 1'b0, 128, "R4 R5 R6 R8 fp16 low chunk0");
      run(0, 1, 1'b1, 1'b0, 128, "R4 R5 R8 fp16 low chunk1");
      run(0, 1, 1'b1, 1'b1, 128, "R5 R7 fp16 high chunk1");
      run(0, 0, 1'b1, 1'b1, 128, "R6 R7 fp16 high chunk0");
   endtask

   task automatic t_row_select();
      run(1, 0, 1'b1, 1'b0, 128, "R1 row1 fp16");
      run(1, 1, 1'b0, 1'b1, 128, "R1 row1 bf16");
   endtask

   task automatic t_width();
      run(0, 0, 1'b1, 1'b1, 40, "R9 width 40");
      run(0, 0, 1'b0, 1'b0, 42, "R9 width 42");
      run(0, 1, 1'b1, 1'b0, 72, "R9 width 72 chunk1");
      run(0, 2, 1'b0, 1'b1, 128, "R9 chunk beyond row");
      run(0, 0, 1'b1, 1'b0, 0, "R9 width 0");
   endtask

   task automatic t_hold();
      logic [511:0] prev;
      run(0, 0, 1'b1, 1'b0, 128, "R10 setup");
      prev = out_vec;
      @(negedge clk);
      req_fmt = 1'b0;
      req_hi  = 1'b1;
      check(out_valid == 1'b0, "R10 strobe drops", 512'(out_valid), 512'd0);
      @(negedge clk);
      check(out_vec == prev, "R10 vector held", out_vec, prev);
   endtask

   initial begin
      src[0]=32'h3F800000; bfx[0]=16'h3F80; fpx[0]=16'h3C00;
      src[1]=32'hC0000000; bfx[1]=16'hC000; fpx[1]=16'hC000;
      src[2]=32'h00000000; bfx[2]=16'h0000; fpx[2]=16'h0000;
      src[3]=32'h80000000; bfx[3]=16'h8000; fpx[3]=16'h8000;
      src[4]=32'h7F800000; bfx[4]=16'h7F80; fpx[4]=16'h7C00;
      src[5]=32'hFF800000; bfx[5]=16'hFF80; fpx[5]=16'hFC00;
      src[6]=32'h7FC00000; bfx[6]=16'h7FC0; fpx[6]=16'h7E00;
      src[7]=32'hFF800001; bfx[7]=16'hFFC0; fpx[7]=16'hFE00;
      src[8]=32'h3F808000; bfx[8]=16'h3F80; fpx[8]=16'h3C04;
      src[9]=32'h3F818000; bfx[9]=16'h3F82; fpx[9]=16'h3C0C;
      src[10]=32'h3F801000; bfx[10]=16'h3F80; fpx[10]=16'h3C00;
      src[11]=32'h3F803000; bfx[11]=16'h3F80; fpx[11]=16'h3C02;
      src[12]=32'h477FF000; bfx[12]=16'h4780; fpx[12]=16'h7C00;
      src[13]=32'h477FE000; bfx[13]=16'h4780; fpx[13]=16'h7BFF;
      src[14]=32'h33800000; bfx[14]=16'h3380; fpx[14]=16'h0001;
      src[15]=32'h33000000; bfx[15]=16'h3300; fpx[15]=16'h0000;
      src[16]=32'h33C00000; bfx[16]=16'h33C0; fpx[16]=16'h0002;
      src[17]=32'h387FC000; bfx[17]=16'h3880; fpx[17]=16'h03FF;
      src[18]=32'h387FE000; bfx[18]=16'h3880; fpx[18]=16'h0400;
      src[19]=32'hC7800000; bfx[19]=16'hC780; fpx[19]=16'hFC00;
      src[20]=32'h7F7FFFFF; bfx[20]=16'h7F80; fpx[20]=16'h7C00;
      src[21]=32'h00000001; bfx[21]=16'h0000; fpx[21]=16'h0000;
      src[22]=32'h3F808001; bfx[22]=16'h3F81; fpx[22]=16'h3C04;
      src[23]=32'h40490FDB; bfx[23]=16'h4049; fpx[23]=16'h4248;
      src[24]=32'h41200000; bfx[24]=16'h4120; fpx[24]=16'h4900;
      src[25]=32'hBF000000; bfx[25]=16'hBF00; fpx[25]=16'hB800;
      src[26]=32'h3E800000; bfx[26]=16'h3E80; fpx[26]=16'h3400;
      src[27]=32'h42C80000; bfx[27]=16'h42C8; fpx[27]=16'h5640;
      src[28]=32'hC2F60000; bfx[28]=16'hC2F6; fpx[28]=16'hD7B0;
      src[29]=32'h38800000; bfx[29]=16'h3880; fpx[29]=16'h0400;
      src[30]=32'h38000000; bfx[30]=16'h3800; fpx[30]=16'h0200;
      src[31]=32'hB3800000; bfx[31]=16'hB380; fpx[31]=16'h8001;
      for (int k = 0; k < 32; k++) begin
         rows[0][32*k +: 32] = src[k];
         rows[1][32*k +: 32] = src[k] ^ 32'h80000000;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bf16();
      t_fp16();
      t_row_select();
      t_width();
      t_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog R10 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end
endmodule